// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block switches a group of identical clock outputs off and on in response to an active-low stop request that may change at any time, with no relation to the clock. The request first passes through a synchronizer clocked by the source clock. A small controller then decides, on rising edges, whether the group should run. The decision reaches the outputs through enable registers that load on falling edges. Every output pulse is therefore either a whole high phase of the source clock or absent. A stopped group always rests low.

A hold counter enforces a minimum enabled interval after every restart, and after reset. A stop request that arrives while the hold is still counting is not lost. It takes effect as soon as the hold expires, provided the request is still asserted at that point. A free-running copy of the source clock leaves the block beside the gated group, and the stop request never touches it. A typical chip uses one instance for the fast processor clocks, with a deep hold of 100 cycles. A second instance serves the bus clocks, with a hold of 10 cycles and a single synchronizer stage.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is held and on the first cycles after it, the group runs: `parked_o` is 0 and every gated output copies the source clock.
- R2: `clk_free_o` follows `clk_i` at all times, whatever the stop request does.
- R3: While the group is stopped, every gated output stays at logic 0 for the whole clock period.
- R4: Suppose `stop_n_i` is 0 when rising edge k samples it, the group is running and its hold has expired. Then the last high pulse starts at edge k+SYNC_STAGES, and no pulse starts from edge k+SYNC_STAGES+1 on.
- R5: Suppose the group is stopped and `stop_n_i` is 1 when edge k samples it. Then the first high pulse starts at edge k+SYNC_STAGES+1.
- R6: A gated output is only ever high during a high phase of `clk_i`, and it is high for the whole of that phase. No shortened pulse is ever produced.
- R7: After a restart, and after reset, the group produces at least MIN_ON pulses before it stops. A request held low through that window is deferred, and it takes effect on the first edge at which the hold has expired.
- R8: A stop request that is withdrawn before the hold expires has no effect, and the group keeps running without a gap.
- R9: All NUM_CLK gated outputs carry identical waveforms.
- R10: `parked_o` is 1 exactly during the clock periods in which the group produces no pulse. It changes on the falling edge at which the enable changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock for the group |
| rst_i | input | 1 | Synchronous active-high reset |
| stop_n_i | input | 1 | Asynchronous stop request, active low |
| clk_out_o | output | NUM_CLK | Gated clock group |
| clk_free_o | output | 1 | Ungated free-running copy of the source clock |
| parked_o | output | 1 | 1 while the gated group is parked low |

## Verification
The bench builds the block with SYNC_STAGES=2, MIN_ON=8 and NUM_CLK=5. With a hold of 8, the deferral window sits well inside a short run. Stop pulses of random length therefore land before, at and after the hold expiry, and both the deferred case and the withdrawn case occur many times. With two synchronizer stages, the off latency and the on latency differ by one edge from their single-stage values. Five copies leave room for a copy that drifts away from the others.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

  // Width of a down-counter that must hold the value n-1 (never below 1 bit)
  function automatic int unsigned hold_bits(input int unsigned n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

  typedef enum logic {
    GATE_PARKED  = 1'b0,
    GATE_RUNNING = 1'b1
  } gate_state_e;

endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic sync_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b1;
        else     q <= async_n;
      end
      assign sync_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_n};
      end
      assign sync_n = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
  import clk_gate_pkg::*;
#(
  parameter int unsigned MIN_ON = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  output logic run_o
);

  localparam int unsigned CW = hold_bits(MIN_ON);
  localparam logic [CW-1:0] HOLD_LOAD = CW'(MIN_ON - 1);

  gate_state_e state_q;
  logic [CW-1:0] hold_q;
  logic hold_done;

  assign hold_done = (hold_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GATE_RUNNING;
      hold_q  <= HOLD_LOAD;
    end else begin
      case (state_q)
        GATE_RUNNING: begin
          if (!hold_done)  hold_q <= hold_q - 1'b1;
          else if (!req_n) state_q <= GATE_PARKED;
        end
        default: begin
          if (req_n) begin
            state_q <= GATE_RUNNING;
            hold_q  <= HOLD_LOAD;
          end
        end
      endcase
    end
  end

  assign run_o = (state_q == GATE_RUNNING);

  // R4
  stop_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run_o) |-> ($past(hold_q) == '0));

  // R8
  stop_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run_o) |-> !$past(req_n));

  // R5
  start_needs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_o) |-> $past(req_n));

  // R7
  hold_idle_when_parked_chk: assert property (@(posedge clk) disable iff (rst)
    !run_o |-> (hold_q == '0));

endmodule

// File: rtl/gate_cell.sv
module gate_cell #(
  parameter int unsigned COPIES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  output logic [COPIES-1:0] gated_o,
  output logic              parked_o
);

  logic [COPIES-1:0] en_q;
  logic parked_q;

  // Enables load on the falling edge, so they only move while clk is low.
  generate
    for (genvar i = 0; i < COPIES; i++) begin : g_copy
      always_ff @(negedge clk) begin
        if (rst) en_q[i] <= 1'b1;
        else     en_q[i] <= run_i;
      end
      assign gated_o[i] = clk & en_q[i];
    end
  endgenerate

  always_ff @(negedge clk) begin
    if (rst) parked_q <= 1'b0;
    else     parked_q <= !run_i;
  end

  assign parked_o = parked_q;

  // R10
  parked_low_chk: assert property (@(negedge clk) disable iff (rst)
    parked_o |-> (gated_o == '0));

  // R9
  copies_aligned_chk: assert property (@(negedge clk) disable iff (rst)
    ($countones(gated_o) == 0) || ($countones(gated_o) == COPIES));

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int unsigned NUM_CLK     = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_ON      = 100
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               stop_n_i,
  output logic [NUM_CLK-1:0] clk_out_o,
  output logic               clk_free_o,
  output logic               parked_o
);

  logic req_n_sync;
  logic run;

  stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_i),
    .rst     (rst_i),
    .async_n (stop_n_i),
    .sync_n  (req_n_sync)
  );

  run_ctrl #(.MIN_ON(MIN_ON)) u_ctrl (
    .clk   (clk_i),
    .rst   (rst_i),
    .req_n (req_n_sync),
    .run_o (run)
  );

  gate_cell #(.COPIES(NUM_CLK)) u_gate (
    .clk      (clk_i),
    .rst      (rst_i),
    .run_i    (run),
    .gated_o  (clk_out_o),
    .parked_o (parked_o)
  );

  assign clk_free_o = clk_i;

  // R2
  free_runs_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    clk_free_o == 1'b1);

endmodule

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb;

  localparam int NCLK = 5;
  localparam int SYNC = 2;
  localparam int MON  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_n = 1'b1;
  logic [NCLK-1:0] gclk;
  logic fclk;
  logic parked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase_tag = "R1";

  always #2 clk = ~clk;

  clk_stop_gate #(.NUM_CLK(NCLK), .SYNC_STAGES(SYNC), .MIN_ON(MON)) u_dut (
    .clk_i(clk), .rst_i(rst), .stop_n_i(stop_n),
    .clk_out_o(gclk), .clk_free_o(fclk), .parked_o(parked)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [NCLK-1:0] fill(input bit v);
    return v ? '1 : '0;
  endfunction

  // Reference model state
  bit m_run = 1'b1;
  bit m_prev = 1'b1;
  int m_pulses = 0;
  logic [SYNC-1:0] m_hist = '1;
  int since_rst = 0;

  initial begin
    forever begin
      logic s_req;
      logic s_rst;
      string tag;
      @(posedge clk);
      s_req = stop_n;
      s_rst = rst;
      #1;
      if (s_rst) begin
        m_run = 1'b1; m_prev = 1'b1; m_pulses = 0; m_hist = '1; since_rst = 0;
      end else begin
        since_rst++;
        if (since_rst == 1) check("R1", {31'd0, parked}, 32'd0);
        check("R2", {31'd0, fclk}, 32'd1);
        check("R9", {31'd0, (gclk == '0) || (gclk == '1)}, 32'd1);
        if (!m_run && m_prev)      tag = "R4";
        else if (m_run && !m_prev) tag = "R5";
        else if (!m_run)           tag = "R3";
        else                       tag = phase_tag;
        check(tag, 32'(gclk), 32'(fill(m_run)));
        check("R10", {31'd0, parked}, {31'd0, !m_run});
        #2;
        check("R6", 32'(gclk), 32'd0);
        check("R2", {31'd0, fclk}, 32'd0);
        // decision at this edge
        if (m_run) m_pulses++;
        m_prev = m_run;
        if (m_run && m_pulses >= MON && !m_hist[SYNC-1]) m_run = 1'b0;
        else if (!m_run && m_hist[SYNC-1]) begin m_run = 1'b1; m_pulses = 0; end
        m_hist = {m_hist[SYNC-2:0], s_req};
      end
    end
  end

  task automatic drive(input bit v, input int cycles);
    @(negedge clk);
    stop_n = v;
    repeat (cycles - 1) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2468));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 3);
    // R7: request right after reset is deferred until hold expires
    phase_tag = "R7";
    drive(1'b0, 25);
    drive(1'b1, SYNC + 2);
    drive(1'b0, 20);
    // R8: short request inside the hold window is dropped
    phase_tag = "R8";
    drive(1'b1, SYNC + 2);
    drive(1'b0, 2);
    drive(1'b1, 30);
    drive(1'b0, 1);
    drive(1'b1, 20);
    // R4/R5 corner: one-cycle low and one-cycle high after expiry
    phase_tag = "R7";
    drive(1'b0, 1);
    drive(1'b1, 15);
    drive(1'b0, 12);
    drive(1'b1, 1);
    drive(1'b0, 12);
    // random mix
    for (int i = 0; i < 400; i++) drive(1'($urandom % 2), 1 + int'($urandom % 14));
    drive(1'b1, 20);
    // mid-run reset: group must run at once (R1)
    phase_tag = "R1";
    drive(1'b0, 30);
    rst = 1'b1;
    drive(1'b0, 3);
    rst = 1'b0;
    stop_n = 1'b1;
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule